// File: doc/BRIEF.md
# UART Interrupt Identification Arbiter

This block decides which of the five interrupt causes of a 16550-style serial port is reported to the processor. It also drives the single level-sensitive interrupt line. It takes the enable register value and the overrun and break events from the receiver. It also takes the parity and framing error levels, the receive FIFO fill count and trigger level, the data-ready flag, a character-timeout pending flag, the holding-register-empty state and the modem-status change bits. It then presents the value the processor reads from the identification register.

The block owns the little state that depends on register reads. It keeps a transmit-empty pending flag, which is cleared by reading the identification register while it reports that cause. It keeps sticky overrun and break flags, which are cleared by reading the line status register. It also registers the FIFO mode. The shifter, the baud timer and the FIFO memories sit outside. They present their state as counts, levels and one-cycle event strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: Causes are ranked, highest first: line status, character timeout, data available, transmit empty, modem change. Only the highest active cause is reported.
- R2: `iirOut[3:0]` reads 0x6 for line status, 0xC for character timeout, 0x4 for data available, 0x2 for transmit empty, 0x0 for modem change, and 0x1 when no cause is active. `iirOut[5:4]` always read 0.
- R3: The line-status cause is active when `ierVal[2]` is 1 and any of these four is set: the sticky overrun flag, `parErr`, `frmErr` or the sticky break flag.
- R4: The character-timeout cause is active when `timeoutPend` is 1 and `ierVal[0]` is 1. It has no enable bit of its own.
- R5: The data-available cause needs `ierVal[0]`. In FIFO mode it is active when `rxCount >= rxTrigger`. Otherwise it is active when `dataReady` is 1.
- R6: The FIFO mode register loads `fifoEn` on every clock. `iirOut[7:6]` read 2'b11 while the mode register is 1, and 2'b00 otherwise.
- R7: An `iirRead` cycle in which `iirOut[3:0]` is 0x2 clears the transmit-empty pending flag from the next cycle on. An `iirRead` that shows any other code leaves the flag unchanged.
- R8: An `lsrRead` cycle clears the sticky overrun and break flags from the next cycle on. `lsrErr` is {break, framing, parity, overrun}, with overrun in bit 0. The framing and parity bits follow `frmErr` and `parErr` directly.
- R9: The transmit-empty pending flag is set on the next cycle by `thrEmptyEvt`, or by `ierWrite` while `thrEmpty` is 1. It is cleared by `thrWrite`. When a set and a clear fall in the same cycle, the set wins.
- R10: `irq` is 1 exactly when `iirOut[0]` is 0. `irq` and `iirOut` follow input changes in the same cycle, with no register in between.
- R11: While `rst_n` is low and the inputs are idle, `iirOut` is 0x01, `irq` is 0 and `lsrErr` is 0.
- R12: An `ovrSet` or `brkSet` pulse sets its sticky flag on the next cycle. A pulse in the same cycle as `lsrRead` wins over the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ierVal | input | 4 | Enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line status, bit3 modem |
| ierWrite | input | 1 | One-cycle strobe: enable register written |
| fifoEn | input | 1 | FIFO mode enable |
| rxCount | input | CNT_W | Receive FIFO fill count |
| rxTrigger | input | CNT_W | Receive trigger level |
| dataReady | input | 1 | Receive data ready |
| timeoutPend | input | 1 | Character timeout pending |
| ovrSet | input | 1 | Overrun event strobe |
| brkSet | input | 1 | Break event strobe |
| parErr | input | 1 | Parity error level |
| frmErr | input | 1 | Framing error level |
| thrEmpty | input | 1 | Holding register empty level |
| thrEmptyEvt | input | 1 | Strobe: holding register just became empty |
| thrWrite | input | 1 | Strobe: holding register written |
| msDelta | input | 4 | Modem status change bits |
| iirRead | input | 1 | Strobe: identification register read |
| lsrRead | input | 1 | Strobe: line status register read |
| iirOut | output | 8 | Identification register value |
| irq | output | 1 | Level interrupt output |
| lsrErr | output | 4 | {break, framing, parity, overrun} |

## Verification
The only internal state is the transmit-empty pending flag, the two sticky error flags and the FIFO mode bit. A wrong value in any of them shows up at the ports on the next clock. It shows in `lsrErr`, in `iirOut[7:6]`, or in the reported code once higher-ranked causes are quiet. A fault in the ranking or the encoding shows up in the same cycle. The bench therefore compares every port against a behavioural model on every clock. It steers directed sequences so that each piece of state is the highest active cause at some point, and then adds random traffic.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_TMO  = 4'hC;
  localparam logic [3:0] CODE_RDA  = 4'h4;
  localparam logic [3:0] CODE_THR  = 4'h2;
  localparam logic [3:0] CODE_MSR  = 4'h0;
  localparam logic [3:0] CODE_NONE = 4'h1;

  typedef struct packed {
    logic thrSet;
    logic thrClr;
    logic errClr;
  } irq_strobe_t;

  // Code for request index; index 0 is the highest rank.
  function automatic logic [3:0] srcCode(input int idx);
    case (idx)
      0:       srcCode = CODE_LINE;
      1:       srcCode = CODE_TMO;
      2:       srcCode = CODE_RDA;
      3:       srcCode = CODE_THR;
      default: srcCode = CODE_MSR;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iirRead,
  input  logic        lsrRead,
  input  logic        ierWrite,
  input  logic        thrWrite,
  input  logic        thrEmptyEvt,
  input  logic        thrEmpty,
  input  logic [3:0]  curCode,
  output irq_strobe_t strb
);
  always_comb begin
    strb.thrSet = thrEmptyEvt | (ierWrite & thrEmpty);
    strb.thrClr = thrWrite | (iirRead & (curCode == CODE_THR));
    strb.errClr = lsrRead;
  end

  // R7
  iir_other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iirRead && curCode != CODE_THR && !thrWrite) |-> !strb.thrClr);

  // R9
  ier_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ierWrite && thrEmpty) |-> strb.thrSet);
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irq_strobe_t      strb,
  input  logic [3:0]       ierVal,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             dataReady,
  input  logic             timeoutPend,
  input  logic             ovrSet,
  input  logic             brkSet,
  input  logic             parErr,
  input  logic             frmErr,
  input  logic [3:0]       msDelta,
  output logic [7:0]       iirOut,
  output logic             irqOut,
  output logic [3:0]       lsrErr,
  output logic [3:0]       curCode
);
  logic thrPendQ, ovrQ, brkQ, fifoModeQ;
  logic [NUM_SRC-1:0] req, grant;
  logic rdaHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thrPendQ  <= 1'b0;
      ovrQ      <= 1'b0;
      brkQ      <= 1'b0;
      fifoModeQ <= 1'b0;
    end else begin
      fifoModeQ <= fifoEn;
      if (strb.thrSet)      thrPendQ <= 1'b1;
      else if (strb.thrClr) thrPendQ <= 1'b0;
      if (ovrSet)           ovrQ <= 1'b1;
      else if (strb.errClr) ovrQ <= 1'b0;
      if (brkSet)           brkQ <= 1'b1;
      else if (strb.errClr) brkQ <= 1'b0;
    end
  end

  assign lsrErr = {brkQ, frmErr, parErr, ovrQ};
  assign rdaHit = fifoModeQ ? (rxCount >= rxTrigger) : dataReady;

  always_comb begin
    req[0] = ierVal[2] & (|lsrErr);
    req[1] = ierVal[0] & timeoutPend;
    req[2] = ierVal[0] & rdaHit;
    req[3] = ierVal[1] & thrPendQ;
    req[4] = ierVal[3] & (|msDelta);
  end

  // Fixed-rank pick: first set request wins.
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    curCode = (grant == '0) ? CODE_NONE : 4'h0;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant[i]) curCode = curCode | srcCode(i);
  end

  assign iirOut = {fifoModeQ, fifoModeQ, 2'b00, curCode};
  assign irqOut = ~curCode[0];

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ierVal[2] && (ovrQ || brkQ || parErr || frmErr)) |-> iirOut[3:0] == CODE_LINE);

  // R4
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ierVal[0] |-> (iirOut[3:0] != CODE_TMO && iirOut[3:0] != CODE_RDA));

  // R6
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoEn |=> iirOut[7:6] == 2'b11);

  // R8
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.errClr && !ovrSet && !brkSet) |=> (!ovrQ && !brkQ));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovrSet |=> lsrErr[0]);

  // R9
  thr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.thrSet |=> thrPendQ);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ierVal,
  input  logic             ierWrite,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             dataReady,
  input  logic             timeoutPend,
  input  logic             ovrSet,
  input  logic             brkSet,
  input  logic             parErr,
  input  logic             frmErr,
  input  logic             thrEmpty,
  input  logic             thrEmptyEvt,
  input  logic             thrWrite,
  input  logic [3:0]       msDelta,
  input  logic             iirRead,
  input  logic             lsrRead,
  output logic [7:0]       iirOut,
  output logic             irq,
  output logic [3:0]       lsrErr
);
  irq_strobe_t strb;
  logic [3:0]  curCode;

  uart_irq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .iirRead(iirRead), .lsrRead(lsrRead),
    .ierWrite(ierWrite), .thrWrite(thrWrite), .thrEmptyEvt(thrEmptyEvt),
    .thrEmpty(thrEmpty), .curCode(curCode), .strb(strb)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .ierVal(ierVal), .fifoEn(fifoEn),
    .rxCount(rxCount), .rxTrigger(rxTrigger), .dataReady(dataReady),
    .timeoutPend(timeoutPend), .ovrSet(ovrSet), .brkSet(brkSet),
    .parErr(parErr), .frmErr(frmErr), .msDelta(msDelta),
    .iirOut(iirOut), .irqOut(irq), .lsrErr(lsrErr), .curCode(curCode)
  );
endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ierVal = '0;
  logic ierWrite = 0, fifoEn = 0, dataReady = 0, timeoutPend = 0;
  logic [CNT_W-1:0] rxCount = '0, rxTrigger = '0;
  logic ovrSet = 0, brkSet = 0, parErr = 0, frmErr = 0;
  logic thrEmpty = 0, thrEmptyEvt = 0, thrWrite = 0;
  logic [3:0] msDelta = '0;
  logic iirRead = 0, lsrRead = 0;
  logic [7:0] iirOut;
  logic irq;
  logic [3:0] lsrErr;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  string curReq = "R11";

  // behavioural model state
  bit mThr = 0, mOvr = 0, mBrk = 0, mFifo = 0;
  bit nThr, nOvr, nBrk, nFifo;

  always #5 clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ierVal(ierVal), .ierWrite(ierWrite),
    .fifoEn(fifoEn), .rxCount(rxCount), .rxTrigger(rxTrigger),
    .dataReady(dataReady), .timeoutPend(timeoutPend), .ovrSet(ovrSet),
    .brkSet(brkSet), .parErr(parErr), .frmErr(frmErr), .thrEmpty(thrEmpty),
    .thrEmptyEvt(thrEmptyEvt), .thrWrite(thrWrite), .msDelta(msDelta),
    .iirRead(iirRead), .lsrRead(lsrRead), .iirOut(iirOut), .irq(irq),
    .lsrErr(lsrErr)
  );

  function automatic int modelCode();
    int rx;
    rx = mFifo ? ((rxCount >= rxTrigger) ? 1 : 0) : (dataReady ? 1 : 0);
    if (ierVal[2] && (mOvr || mBrk || parErr || frmErr)) return 6;
    if (ierVal[0] && timeoutPend) return 12;
    if (ierVal[0] && rx == 1) return 4;
    if (ierVal[1] && mThr) return 2;
    if (ierVal[3] && msDelta != 0) return 0;
    return 1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One clock: compare at the falling edge, advance the model, clear strobes after the rise.
  task automatic tick(input int expNib = -1);
    int code;
    int expIir;
    @(negedge clk);
    code = modelCode();
    expIir = (mFifo ? 8'hC0 : 8'h00) | code;
    check(curReq, "iir", int'(iirOut), expIir);
    check("R10", "irq", int'(irq), (code != 1) ? 1 : 0);
    check("R8", "lsrErr", int'(lsrErr), {mBrk, frmErr, parErr, mOvr});
    if (expNib >= 0) check(curReq, "code", int'(iirOut[3:0]), expNib);
    nFifo = fifoEn;
    nThr = mThr;
    if (thrEmptyEvt || (ierWrite && thrEmpty)) nThr = 1;
    else if (thrWrite || (iirRead && code == 2)) nThr = 0;
    nOvr = ovrSet ? 1 : (lsrRead ? 0 : mOvr);
    nBrk = brkSet ? 1 : (lsrRead ? 0 : mBrk);
    @(posedge clk);
    #1;
    mFifo = nFifo; mThr = nThr; mOvr = nOvr; mBrk = nBrk;
    ierWrite = 0; ovrSet = 0; brkSet = 0; thrEmptyEvt = 0;
    thrWrite = 0; iirRead = 0; lsrRead = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk);
    check("R11", "iir in reset", int'(iirOut), 8'h01);
    check("R11", "irq in reset", int'(irq), 0);
    check("R11", "lsrErr in reset", int'(lsrErr), 0);
    @(posedge clk); #1 rst_n = 1;
    tick(1);

    // R1 all causes at once; the sticky overrun lands one cycle later
    curReq = "R1";
    ierVal = 4'hF; ovrSet = 1; timeoutPend = 1; dataReady = 1;
    thrEmptyEvt = 1; msDelta = 4'h1;
    tick(12);
    curReq = "R3"; tick(6);
    lsrRead = 1; tick(6);
    curReq = "R1"; tick(12);
    curReq = "R5"; timeoutPend = 0; tick(4);
    curReq = "R1"; dataReady = 0; tick(2);
    curReq = "R7"; iirRead = 1; tick(2);
    curReq = "R1"; tick(0);
    curReq = "R2"; msDelta = 0; tick(1);

    // R4 timeout and data need the receive enable
    curReq = "R4"; ierVal = 4'hE; timeoutPend = 1; dataReady = 1; tick(1);
    timeoutPend = 0; dataReady = 0;

    // R9 enable write re-arms, holding write clears
    curReq = "R9"; ierVal = 4'h2; thrEmpty = 1; ierWrite = 1; tick(1);
    tick(2);
    thrWrite = 1; tick(2);
    tick(1);
    thrWrite = 1; thrEmptyEvt = 1; tick(1);
    tick(2);

    // R7 a read showing another code keeps the pending flag
    curReq = "R7"; ierVal = 4'h3; dataReady = 1; iirRead = 1; tick(4);
    dataReady = 0; tick(2);

    // R5 and R6 FIFO mode
    curReq = "R6"; fifoEn = 1; ierVal = 4'h1; rxTrigger = 5'd4; rxCount = 5'd3;
    dataReady = 1; tick(4);
    curReq = "R5"; tick(1);
    rxCount = 5'd4; tick(4);
    rxCount = 5'd14; rxTrigger = 5'd14; dataReady = 0; tick(4);
    curReq = "R6"; fifoEn = 0; tick(4);
    curReq = "R5"; tick(1);

    // R12 set wins over same-cycle read, R8 read clears
    curReq = "R12"; ierVal = 4'h4; ovrSet = 1; lsrRead = 1; tick(1);
    tick(6);
    curReq = "R8"; lsrRead = 1; tick(6);
    tick(1);
    curReq = "R12"; brkSet = 1; tick(1);
    tick(6);
    curReq = "R8"; parErr = 1; lsrRead = 1; tick(6);
    tick(6);
    parErr = 0; frmErr = 1; tick(6);
    frmErr = 0; tick(1);

    // R2 random traffic against the model
    curReq = "R2";
    for (int i = 0; i < 600; i++) begin
      ierVal = 4'($urandom);
      fifoEn = ($urandom % 4) != 0;
      rxCount = 5'($urandom % 17);
      case ($urandom % 4)
        0: rxTrigger = 5'd1;
        1: rxTrigger = 5'd4;
        2: rxTrigger = 5'd8;
        default: rxTrigger = 5'd14;
      endcase
      dataReady = ($urandom % 2) == 1;
      timeoutPend = ($urandom % 5) == 0;
      parErr = ($urandom % 9) == 0;
      frmErr = ($urandom % 9) == 0;
      msDelta = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      thrEmpty = ($urandom % 2) == 1;
      ovrSet = ($urandom % 8) == 0;
      brkSet = ($urandom % 8) == 0;
      thrEmptyEvt = ($urandom % 4) == 0;
      thrWrite = ($urandom % 4) == 0;
      ierWrite = ($urandom % 4) == 0;
      iirRead = ($urandom % 3) == 0;
      lsrRead = ($urandom % 3) == 0;
      tick();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule